// File: doc/BRIEF.md
# Latched 16-bit Interval Timer

This block is a down-counting interval timer that sits on a byte-wide processor register bus. Software sets a 16-bit start value through two 8-bit reload latches. Writing the upper byte through the counter address copies both latches into the counter and starts it. From then on the counter steps down by one on every cycle in which the count-enable `tick` input is high. When the count passes through zero, the block can raise an interrupt flag, and in free-running mode it also reloads the counter from the latches.

Two control bits give four modes. The mode bit picks one-shot or free-running behaviour. The output-enable bit routes a waveform to `tmr_pin`. In one-shot mode that waveform is a single low pulse, which starts at load and ends at the first timeout. In free-running mode it is a square wave that inverts at every timeout. The interrupt request is the timeout flag gated by an enable bit. Some register accesses have side effects on the flag, and the requirements below define them.

Top module: `ivl_timer`

## Requirements
- R1: A write to address 0 (counter low) or address 2 (latch low) stores the byte in the low latch. A write to address 3 (latch high) stores it in the high latch. None of these three writes changes the counter or the flag.
- R2: A write to address 1 (counter high) does four things at that clock edge: it stores the byte in the high latch, loads the counter with {written byte, low latch}, clears the flag, and arms the one-shot.
- R3: Reads are combinational. Address 0 returns counter[7:0] and address 1 returns counter[15:8]. Address 2 returns the low latch and address 3 the high latch. Address 4 returns {6'b0, pin enable, free-run}. Address 5 returns {7'b0, flag} and address 6 returns {7'b0, interrupt enable}. Address 7 returns 0.
- R4: A read of address 0 clears the flag at the end of the cycle. Reads of any other address, including the latch addresses, leave the flag as it was.
- R5: The counter decrements by one on each clock edge with `tick` high and no load. Without `tick` it holds.
- R6: A timeout is a `tick` while the counter is zero and no load is under way. One-shot mode is control bit 0 = 0. In this mode the counter wraps to 16'hFFFF at a timeout, and the flag is set only on the first timeout after a load.
- R7: Free-run mode is control bit 0 = 1. In this mode every timeout reloads the counter from the latch values held before that edge, and sets the flag.
- R8: Writing address 5 with bit 0 = 1 clears the flag, and writing it with bit 0 = 0 has no effect. A flag-setting timeout wins over a clear in the same cycle. A load wins over a `tick` in the same cycle.
- R9: `irq` is high exactly when the flag is set and the interrupt enable (address 6, bit 0) is 1.
- R10: With control bit 1 = 0, `tmr_pin` is 1. With it set, `tmr_pin` shows the internal pin state. A load drives that state low. A one-shot flag-setting timeout drives it high, and each free-run timeout inverts it.
- R11: After reset the counter, both latches, the flag, the interrupt enable and both control bits are 0, the one-shot is disarmed, and the internal pin state is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one decrement per high cycle |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| tmr_pin | output | 1 | Timer waveform output |

## Verification
Directed sequences come first. Latch-only writes are followed by counter reads, which separates latch storage from counter loading. A short one-shot count runs through zero, and then runs a full 65536-tick lap to a second zero crossing, which separates first-timeout flagging from repeated flagging. A short free-run count shows that reloading uses the latch values and that the pin inverts. Timeouts are then placed in the same cycle as a flag clear, and a `tick` in the same cycle as a load, to expose the priority rules. After that, a long stream of seeded random accesses and ticks runs against a reference model. The stream is biased towards small load values so that many zero crossings occur under both modes, and it exposes any wrong read side effect or mis-decoded address.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

   typedef enum logic [2:0] {
      A_CNT_LO = 3'd0,
      A_CNT_HI = 3'd1,
      A_LAT_LO = 3'd2,
      A_LAT_HI = 3'd3,
      A_CTRL   = 3'd4,
      A_FLAG   = 3'd5,
      A_IEN    = 3'd6,
      A_NONE   = 3'd7
   } reg_addr_e;

   localparam int CTRL_FREE_BIT = 0;
   localparam int CTRL_PIN_BIT  = 1;
   localparam int FLAG_BIT      = 0;
   localparam int IEN_BIT       = 0;

endpackage

// File: rtl/timer_regs.sv
module timer_regs
   import ivl_timer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              load_o,
   output logic              flag_clr_o,
   output logic [CNT_W-1:0]  load_val_o,
   output logic [CNT_W-1:0]  reload_val_o,
   output logic              free_run_o,
   output logic              pin_en_o,
   output logic              irq_en_o
);

   localparam int HALF_W = CNT_W / 2;

   reg_addr_e         a;
   logic [DATA_W-1:0] lat_lo_q, lat_hi_q;
   logic              free_q, pin_en_q, ien_q;
   logic              wr, rd;

   assign a  = reg_addr_e'(addr);
   assign wr = cs & we;
   assign rd = cs & ~we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_lo_q <= '0;
         lat_hi_q <= '0;
         free_q   <= 1'b0;
         pin_en_q <= 1'b0;
         ien_q    <= 1'b0;
      end else if (wr) begin
         case (a)
            A_CNT_LO, A_LAT_LO: lat_lo_q <= wdata;
            A_CNT_HI, A_LAT_HI: lat_hi_q <= wdata;
            A_CTRL: begin
               free_q   <= wdata[CTRL_FREE_BIT];
               pin_en_q <= wdata[CTRL_PIN_BIT];
            end
            A_IEN:   ien_q <= wdata[IEN_BIT];
            default: ;
         endcase
      end
   end

   assign load_o       = wr & (a == A_CNT_HI);
   assign flag_clr_o   = (rd & (a == A_CNT_LO)) | (wr & (a == A_FLAG) & wdata[FLAG_BIT]);
   assign load_val_o   = {wdata, lat_lo_q};
   assign reload_val_o = {lat_hi_q, lat_lo_q};
   assign free_run_o   = free_q;
   assign pin_en_o     = pin_en_q;
   assign irq_en_o     = ien_q;

   always_comb begin
      rdata_o = '0;
      case (a)
         A_CNT_LO: rdata_o = cnt_i[HALF_W-1:0];
         A_CNT_HI: rdata_o = cnt_i[CNT_W-1:HALF_W];
         A_LAT_LO: rdata_o = lat_lo_q;
         A_LAT_HI: rdata_o = lat_hi_q;
         A_CTRL: begin
            rdata_o[CTRL_FREE_BIT] = free_q;
            rdata_o[CTRL_PIN_BIT]  = pin_en_q;
         end
         A_FLAG:  rdata_o[FLAG_BIT] = flag_i;
         A_IEN:   rdata_o[IEN_BIT]  = ien_q;
         default: rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/timer_core.sv
module timer_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             free_run,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o,
   output logic             timeout_o,
   output logic             fire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q, armed_q;
   logic             at_zero;

   assign at_zero   = (cnt_q == '0);
   assign timeout_o = tick & ~load & at_zero;
   assign fire_o    = timeout_o & (free_run | armed_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         armed_q <= 1'b1;
      end else if (tick) begin
         if (at_zero && free_run) cnt_q <= reload_val;
         else                     cnt_q <= cnt_q - 1'b1;
         if (fire_o && !free_run) armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (fire_o)           flag_q <= 1'b1;
      else if (load || flag_clr) flag_q <= 1'b0;
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

   // R2
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)) && !flag_q && armed_q);

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q));

   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && !at_zero) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

   // R7
   free_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && free_run) |=> (cnt_q == $past(reload_val)) && flag_q);

   // R6
   one_shot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && !free_run && !armed_q) |=> !$rose(flag_q));

endmodule

// File: rtl/timer_pin.sv
module timer_pin #(
   parameter bit HAS_PIN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic timeout,
   input  logic fire,
   input  logic free_run,
   input  logic pin_en,
   output logic pin_o
);

   generate
      if (HAS_PIN) begin : g_pin
         logic pin_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   pin_q <= 1'b1;
            else if (load)                pin_q <= 1'b0;
            else if (timeout && free_run) pin_q <= ~pin_q;
            else if (fire)                pin_q <= 1'b1;
         end

         assign pin_o = pin_en ? pin_q : 1'b1;

         // R10
         pin_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> !pin_q);

         // R10
         pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (timeout && free_run) |=> pin_q != $past(pin_q));

         // R10
         pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_en |-> pin_o);
      end else begin : g_nopin
         assign pin_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
   import ivl_timer_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 16,
   parameter bit HAS_PIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cs,
   input  logic              we,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              tmr_pin
);

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_width
         $error("ivl_timer: CNT_W must be twice DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("ivl_timer: DATA_W must hold the two control bits");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, load_val, reload_val;
   logic             flag, load, flag_clr, free_run, pin_en, irq_en;
   logic             timeout, fire;

   timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs           (cs),
      .we           (we),
      .addr         (addr),
      .wdata        (wdata),
      .cnt_i        (cnt),
      .flag_i       (flag),
      .rdata_o      (rdata),
      .load_o       (load),
      .flag_clr_o   (flag_clr),
      .load_val_o   (load_val),
      .reload_val_o (reload_val),
      .free_run_o   (free_run),
      .pin_en_o     (pin_en),
      .irq_en_o     (irq_en)
   );

   timer_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .load       (load),
      .load_val   (load_val),
      .reload_val (reload_val),
      .free_run   (free_run),
      .flag_clr   (flag_clr),
      .cnt_o      (cnt),
      .flag_o     (flag),
      .timeout_o  (timeout),
      .fire_o     (fire)
   );

   timer_pin #(.HAS_PIN(HAS_PIN)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .timeout  (timeout),
      .fire     (fire),
      .free_run (free_run),
      .pin_en   (pin_en),
      .pin_o    (tmr_pin)
   );

   assign irq = flag & irq_en;

   // R4
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !we && addr == A_CNT_LO && !fire) |=> !flag);

   // R1
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we && addr != A_CNT_HI && !tick) |=> $stable(cnt));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> flag);

endmodule

// File: tb/tb_ivl_timer.sv
module tb_ivl_timer;

   logic       clk = 1'b0;
   logic       rst_n, tick, cs, we;
   logic [2:0] addr;
   logic [7:0] wdata, rdata;
   logic       irq, tmr_pin;

   always #2 clk = ~clk;

   ivl_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .tmr_pin(tmr_pin)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [15:0] m_cnt;
   logic [7:0]  m_llo, m_lhi;
   bit          m_flag, m_armed, m_pin, m_free, m_pen, m_ien;

   function automatic logic [7:0] exp_rd(logic [2:0] a);
      case (a)
         3'd0:    return m_cnt[7:0];
         3'd1:    return m_cnt[15:8];
         3'd2:    return m_llo;
         3'd3:    return m_lhi;
         3'd4:    return {6'b0, m_pen, m_free};
         3'd5:    return {7'b0, m_flag};
         3'd6:    return {7'b0, m_ien};
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit exp_pin();
      return m_pen ? m_pin : 1'b1;
   endfunction

   function automatic void model_reset();
      m_cnt = '0; m_llo = '0; m_lhi = '0;
      m_flag = 0; m_armed = 0; m_pin = 1; m_free = 0; m_pen = 0; m_ien = 0;
   endfunction

   function automatic void model_update(bit c, bit w, logic [2:0] a, logic [7:0] d, bit t);
      bit         ld, clr, to, fire, ofree;
      logic [7:0] ollo, olhi;
      ld    = c && w && a == 3'd1;
      clr   = (c && !w && a == 3'd0) || (c && w && a == 3'd5 && d[0]);
      to    = t && !ld && m_cnt == 16'h0;
      fire  = to && (m_free || m_armed);
      ollo  = m_llo;
      olhi  = m_lhi;
      ofree = m_free;
      if (c && w) begin
         case (a)
            3'd0, 3'd2: m_llo = d;
            3'd1, 3'd3: m_lhi = d;
            3'd4: begin m_free = d[0]; m_pen = d[1]; end
            3'd6: m_ien = d[0];
            default: ;
         endcase
      end
      if (ld) begin
         m_cnt = {d, ollo}; m_armed = 1; m_pin = 0;
      end else if (t) begin
         m_cnt = (m_cnt == 16'h0 && ofree) ? {olhi, ollo} : m_cnt - 16'h1;
         if (to && ofree) m_pin = !m_pin;
         else if (fire)   m_pin = 1;
         if (fire && !ofree) m_armed = 0;
      end
      if (fire)           m_flag = 1;
      else if (ld || clr) m_flag = 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(bit c, bit w, logic [2:0] a, logic [7:0] d, bit t, string tag);
      cs = c; we = w; addr = a; wdata = d; tick = t;
      #1;
      if (c && !w) chk(tag, rdata, exp_rd(a));
      chk("R9 irq", irq, m_flag & m_ien);
      chk("R10 pin", tmr_pin, exp_pin());
      @(posedge clk);
      model_update(c, w, a, d, t);
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      step(1, 1, a, d, 0, "R1");
   endtask

   task automatic rd(logic [2:0] a, string tag);
      step(1, 0, a, 8'h00, 0, tag);
   endtask

   task automatic ticks(int n, string tag);
      for (int i = 0; i < n; i++) step(0, 0, 3'd0, 8'h00, 1, tag);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 0; cs = 0; we = 0; addr = 0; wdata = 0; tick = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R11 reset state via every address
      for (int a = 0; a < 8; a++) rd(3'(a), "R11");

      // R1 latch writes do not touch the counter
      wr(3'd0, 8'h05);
      rd(3'd0, "R1");
      wr(3'd3, 8'h77);
      wr(3'd2, 8'h05);
      rd(3'd1, "R1");
      rd(3'd2, "R3");
      rd(3'd3, "R3");

      // R2 load starts count, pin low (one-shot, pin enabled)
      wr(3'd6, 8'h01);
      wr(3'd4, 8'h02);
      rd(3'd4, "R3");
      wr(3'd1, 8'h00);
      rd(3'd0, "R2");
      rd(3'd1, "R2");
      rd(3'd3, "R2");

      // R5 countdown, hold without tick
      ticks(3, "R5");
      rd(3'd0, "R5");
      step(0, 0, 3'd0, 8'h00, 0, "R5");
      rd(3'd0, "R5");

      // R6 first timeout sets flag, wraps to FFFF
      ticks(3, "R6");
      rd(3'd5, "R6");
      rd(3'd1, "R6");

      // R4 latch reads keep the flag, counter-low read clears it
      rd(3'd2, "R4");
      rd(3'd3, "R4");
      rd(3'd5, "R4");
      rd(3'd0, "R4");
      rd(3'd5, "R4");

      // R6 second zero crossing without reload does not flag
      ticks(65536, "R6");
      rd(3'd5, "R6");

      // R7 free-run reload and pin toggling
      wr(3'd4, 8'h03);
      wr(3'd0, 8'h02);
      wr(3'd3, 8'h00);
      wr(3'd1, 8'h00);
      for (int i = 0; i < 9; i++) begin
         step(0, 0, 3'd0, 8'h00, 1, "R7");
         rd(3'd0, "R7");
      end
      rd(3'd5, "R7");

      // R8 write of zero ignored, write of one clears
      wr(3'd5, 8'h00);
      rd(3'd5, "R8");
      wr(3'd5, 8'h01);
      rd(3'd5, "R8");

      // R8 timeout beats clear in same cycle
      while (m_cnt != 16'h0) ticks(1, "R8");
      step(1, 1, 3'd5, 8'h01, 1, "R8");
      rd(3'd5, "R8");

      // R8 load beats tick
      step(1, 1, 3'd1, 8'h01, 1, "R8");
      rd(3'd0, "R8");
      rd(3'd1, "R8");

      // R10 pin disabled drives high
      wr(3'd4, 8'h01);
      ticks(4, "R10");

      // random traffic checked against the model
      for (int i = 0; i < 6000; i++) begin
         bit         c, w, t;
         logic [2:0] a;
         logic [7:0] d;
         c = ($urandom % 3) != 0;
         w = $urandom % 2;
         a = 3'($urandom % 8);
         d = 8'($urandom);
         if (a <= 3'd3 && ($urandom % 4) != 0) d = 8'($urandom % 4);
         t = $urandom % 2;
         step(c, w, a, d, t, "R3");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule